// File: doc/BRIEF.md
# Instruction Pointer Sequencing Unit

This block owns the fetch address of a small processor front end. Each clock cycle it takes one decoded control operation and computes the next address to fetch. The operation can be plain sequential advance, an unconditional jump, a subroutine call or return, a jump taken on the zero flag, a count-down loop branch, a software interrupt entry, or an interrupt return. The length of the current instruction, a branch target, the zero flag and an interrupt number come with the operation.

Calls and interrupt entries save the address of the following instruction on one shared internal save stack. Returns and interrupt returns pop from that same stack. A 16-entry handler table, written through a configuration port, supplies the interrupt entry addresses. A loop count register, loaded through its own strobe, drives the decrement-and-branch operation. Pushing onto a full stack or popping an empty one raises a sticky fault and freezes the pointer for that cycle.

Top module: `ip_seq_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit sets `fetch_addr` to `RESET_ADDR` (default 0x1000), clears `stack_fault`, empties the save stack, zeroes the loop count and zeroes every handler table entry.
- R2: Operation code 0 (sequential) sets the pointer to the old pointer plus the zero-extended `instr_len`, modulo 2^ADDR_W.
- R3: Operation code 1 (jump) loads `target` into the pointer.
- R4: Operation code 2 (call) pushes the old pointer plus `instr_len` onto the save stack and loads `target`.
- R5: Operation code 3 (return) pops the most recently pushed address into the pointer, so that nested calls unwind last-in first-out.
- R6: Operation code 4 (jump if equal) loads `target` when `zero_flag` is 1. Otherwise it advances the pointer as in R2.
- R7: Operation code 5 (loop) decrements the loop count by one, wrapping from 0 to all ones. It loads `target` when the decremented value is nonzero and otherwise advances as in R2.
- R8: When `cnt_load` is 1, the loop count takes `cnt_value`. If an operation code 5 arrives in the same cycle, the load wins: the count becomes `cnt_value`, no decrement happens and the pointer advances as in R2.
- R9: Operation code 6 (software interrupt) pushes the old pointer plus `instr_len` and loads the handler table entry selected by `int_num`. A table write (`vec_we`, `vec_idx`, `vec_addr`) takes effect on the following cycle, so an interrupt in the same cycle as a write to its entry uses the old entry.
- R10: Operation code 7 (interrupt return) pops the shared save stack into the pointer exactly as R5 does. Calls and interrupts can therefore nest in any mix.
- R11: The stack holds 8 entries. A push when it is full, or a pop when it is empty, leaves both the pointer and the stack unchanged and sets `stack_fault`.
- R12: Once `stack_fault` is set it stays at 1 until reset, whatever operations follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 3 | Control operation code (0 to 7, see requirements) |
| instr_len | input | LEN_W (4) | Length of the current instruction |
| target | input | ADDR_W (32) | Branch or call target address |
| zero_flag | input | 1 | Zero flag for the jump-if-equal operation |
| int_num | input | 4 | Handler table index for the software interrupt |
| cnt_load | input | 1 | Load strobe for the loop count |
| cnt_value | input | CNT_W (16) | Value loaded into the loop count |
| vec_we | input | 1 | Handler table write enable |
| vec_idx | input | 4 | Handler table entry to write |
| vec_addr | input | ADDR_W (32) | Handler address to write |
| fetch_addr | output | ADDR_W (32) | Current instruction pointer (next fetch address) |
| stack_fault | output | 1 | Sticky stack overflow or underflow flag |

## Verification
Directed sequences run nested calls and returns to expose any ordering fault in the stack. They run a count of three through the loop to separate the taken and fall-through paths, and zero flag values of both polarities on the conditional jump. Corner cases cover a loop count of zero wrapping around, a count load in the same cycle as a loop, a handler table write in the same cycle as an interrupt on that entry, a pop of an empty stack and a ninth push. After these, a long run of seeded random operations mixes all eight codes with random lengths, targets and table writes. A bench model predicts the pointer and fault flag for every cycle, which shows whether stack depth and sticky fault tracking hold under arbitrary interleaving.

// File: rtl/ipseq_pkg.sv
// Shared types for the instruction pointer sequencing unit.
// Assumes a 3-bit operation code produced by an external decoder.
package ipseq_pkg;

    typedef enum logic [2:0] {
        OP_SEQ  = 3'd0,
        OP_JMP  = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_JEQ  = 3'd4,
        OP_LOOP = 3'd5,
        OP_INT  = 3'd6,
        OP_IRET = 3'd7
    } ipseq_op_e;

endpackage

// File: rtl/ipseq_ret_stack.sv
// Save stack of return addresses, register based.
// Assumes the caller never asserts push and pop together, never pushes
// when full and never pops when empty (the top module filters these).
module ipseq_ret_stack #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 top,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     slots [DEPTH];
    logic [LVL_W-1:0] lvl_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    assign top_idx = IDX_W'(lvl_q - LVL_W'(1));
    assign wr_idx  = IDX_W'(lvl_q);
    assign top     = slots[top_idx];
    assign full    = (lvl_q == LVL_W'(DEPTH));
    assign empty   = (lvl_q == '0);
    assign level   = lvl_q;

    // Track the number of occupied slots; reset empties the stack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (push) begin
            lvl_q <= lvl_q + LVL_W'(1);
        end else if (pop) begin
            lvl_q <= lvl_q - LVL_W'(1);
        end
    end

    // Write the pushed address into the first free slot.
    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_idx] <= din;
        end
    end

endmodule

// File: rtl/ipseq_vec_table.sv
// Handler address table for software interrupts, written through a
// configuration port. A write becomes visible on the next cycle.
module ipseq_vec_table #(
    parameter int unsigned W     = 32,
    parameter int unsigned COUNT = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(COUNT)-1:0]  wr_idx,
    input  logic [W-1:0]              wr_data,
    input  logic [$clog2(COUNT)-1:0]  rd_idx,
    output logic [W-1:0]              rd_data
);
    logic [W-1:0] entries [COUNT];

    assign rd_data = entries[rd_idx];

    // Clear all entries on reset, otherwise apply configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(COUNT); i++) begin
                entries[i] <= '0;
            end
        end else if (we) begin
            entries[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/ipseq_loop_ctr.sv
// Loop count register with load and decrement.
// Assumes load has priority over decrement; take reports whether the
// decremented value is nonzero.
module ipseq_loop_ctr #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          take
);
    logic [CW-1:0] count_q;
    logic [CW-1:0] count_dec;

    assign count_dec = count_q - CW'(1);
    assign take      = (count_dec != '0);

    // Hold the count: reset to zero, load wins over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec) begin
            count_q <= count_dec;
        end
    end

endmodule

// File: rtl/ip_seq_unit.sv
// Instruction pointer sequencing unit: computes the next fetch address
// from one control operation per cycle. Call and software interrupt
// share one save stack; return and interrupt return pop it. Stack
// overflow or underflow freezes the pointer and sets a sticky fault.
// Assumes op and its operands are valid every cycle.
module ip_seq_unit #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned LEN_W       = 4,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned STACK_DEPTH = 8,
    parameter int unsigned VEC_COUNT   = 16,
    parameter int unsigned RESET_ADDR  = 32'h0000_1000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    op,
    input  logic [LEN_W-1:0]              instr_len,
    input  logic [ADDR_W-1:0]             target,
    input  logic                          zero_flag,
    input  logic [$clog2(VEC_COUNT)-1:0]  int_num,
    input  logic                          cnt_load,
    input  logic [CNT_W-1:0]              cnt_value,
    input  logic                          vec_we,
    input  logic [$clog2(VEC_COUNT)-1:0]  vec_idx,
    input  logic [ADDR_W-1:0]             vec_addr,
    output logic [ADDR_W-1:0]             fetch_addr,
    output logic                          stack_fault
);
    import ipseq_pkg::*;

    localparam int unsigned LVL_W = $clog2(STACK_DEPTH + 1);

    ipseq_op_e         op_e;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_next;
    logic [ADDR_W-1:0] seq_addr;
    logic              fault_q;
    logic              fault_set;

    logic              stk_push;
    logic              stk_pop;
    logic [ADDR_W-1:0] stk_top;
    logic              stk_full;
    logic              stk_empty;
    logic [LVL_W-1:0]  stk_level;

    logic [ADDR_W-1:0] vec_rd;
    logic              loop_dec;
    logic              loop_take;

    assign op_e     = ipseq_op_e'(op);
    assign seq_addr = ptr_q + ADDR_W'(instr_len);

    ipseq_ret_stack #(
        .W     (ADDR_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (seq_addr),
        .top   (stk_top),
        .full  (stk_full),
        .empty (stk_empty),
        .level (stk_level)
    );

    ipseq_vec_table #(
        .W     (ADDR_W),
        .COUNT (VEC_COUNT)
    ) u_vectors (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (vec_we),
        .wr_idx  (vec_idx),
        .wr_data (vec_addr),
        .rd_idx  (int_num),
        .rd_data (vec_rd)
    );

    ipseq_loop_ctr #(
        .CW (CNT_W)
    ) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_value),
        .dec      (loop_dec),
        .take     (loop_take)
    );

    // Select the next pointer and the stack action for this operation.
    always_comb begin
        ptr_next  = seq_addr;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        fault_set = 1'b0;
        loop_dec  = 1'b0;
        unique case (op_e)
            OP_SEQ:  ptr_next = seq_addr;
            OP_JMP:  ptr_next = target;
            OP_CALL, OP_INT: begin
                if (stk_full) begin
                    fault_set = 1'b1;
                    ptr_next  = ptr_q;
                end else begin
                    stk_push = 1'b1;
                    ptr_next = (op_e == OP_CALL) ? target : vec_rd;
                end
            end
            OP_RET, OP_IRET: begin
                if (stk_empty) begin
                    fault_set = 1'b1;
                    ptr_next  = ptr_q;
                end else begin
                    stk_pop  = 1'b1;
                    ptr_next = stk_top;
                end
            end
            OP_JEQ:  ptr_next = zero_flag ? target : seq_addr;
            OP_LOOP: begin
                if (!cnt_load) begin
                    loop_dec = 1'b1;
                    ptr_next = loop_take ? target : seq_addr;
                end
            end
            default: ptr_next = seq_addr;
        endcase
    end

    // Register the pointer; reset loads the fixed start address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= ADDR_W'(RESET_ADDR);
        end else begin
            ptr_q <= ptr_next;
        end
    end

    // Sticky fault flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (fault_set) begin
            fault_q <= 1'b1;
        end
    end

    assign fetch_addr  = ptr_q;
    assign stack_fault = fault_q;

endmodule

// File: rtl/ipseq_checker.sv
// Property checker for ip_seq_unit, attached with bind.
// Assumes it sees the top ports plus the stack occupancy signals.
module ipseq_checker #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned LEN_W       = 4,
    parameter int unsigned STACK_DEPTH = 8,
    parameter int unsigned RESET_ADDR  = 32'h0000_1000
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [2:0]                        op,
    input logic [LEN_W-1:0]                  instr_len,
    input logic [ADDR_W-1:0]                 target,
    input logic                              zero_flag,
    input logic                              cnt_load,
    input logic [ADDR_W-1:0]                 fetch_addr,
    input logic                              stack_fault,
    input logic                              stk_empty,
    input logic                              stk_full,
    input logic [$clog2(STACK_DEPTH+1)-1:0]  stk_level
);
    // R1: first cycle after a reset edge shows the start state.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (fetch_addr == ADDR_W'(RESET_ADDR)) && !stack_fault);

    // R2: sequential advance by the instruction length.
    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd0) |=> fetch_addr == ($past(fetch_addr) + ADDR_W'($past(instr_len))));

    // R3: jump loads the target.
    assert_jump_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1) |=> fetch_addr == $past(target));

    // R6: not-taken conditional jump falls through.
    assert_jeq_fallthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd4 && !zero_flag) |=> fetch_addr == ($past(fetch_addr) + ADDR_W'($past(instr_len))));

    // R8: loop coinciding with a load advances sequentially.
    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5 && cnt_load) |=> fetch_addr == ($past(fetch_addr) + ADDR_W'($past(instr_len))));

    // R11: pop on empty freezes the pointer and raises the fault.
    assert_underflow_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 3'd3 || op == 3'd7) && stk_empty) |=> (fetch_addr == $past(fetch_addr)) && stack_fault);

    // R11: push on full freezes the pointer and the occupancy.
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 3'd2 || op == 3'd6) && stk_full) |=> (fetch_addr == $past(fetch_addr)) && $stable(stk_level) && stack_fault);

    // R11: occupancy never exceeds the depth.
    assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_level <= ($clog2(STACK_DEPTH+1))'(STACK_DEPTH));

    // R12: the fault flag is sticky.
    assert_fault_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stack_fault |=> stack_fault);

endmodule

bind ip_seq_unit ipseq_checker #(
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .STACK_DEPTH (STACK_DEPTH),
    .RESET_ADDR  (RESET_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .instr_len   (instr_len),
    .target      (target),
    .zero_flag   (zero_flag),
    .cnt_load    (cnt_load),
    .fetch_addr  (fetch_addr),
    .stack_fault (stack_fault),
    .stk_empty   (stk_empty),
    .stk_full    (stk_full),
    .stk_level   (stk_level)
);

// File: tb/ip_seq_unit_tb.sv
// Self-checking bench: directed corner cases then seeded random operations,
// compared against a behavioural model kept in the bench.
module ip_seq_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] START = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [3:0]  instr_len = 4'd0;
    logic [31:0] target = '0;
    logic        zero_flag = 1'b0;
    logic [3:0]  int_num = '0;
    logic        cnt_load = 1'b0;
    logic [15:0] cnt_value = '0;
    logic        vec_we = 1'b0;
    logic [3:0]  vec_idx = '0;
    logic [31:0] vec_addr = '0;
    logic [31:0] fetch_addr;
    logic        stack_fault;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    logic [31:0] m_ptr;
    logic [31:0] m_stack [8];
    int          m_sp;
    logic [15:0] m_cnt;
    logic [31:0] m_vec [16];
    logic        m_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    ip_seq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op(op), .instr_len(instr_len),
        .target(target), .zero_flag(zero_flag), .int_num(int_num),
        .cnt_load(cnt_load), .cnt_value(cnt_value), .vec_we(vec_we),
        .vec_idx(vec_idx), .vec_addr(vec_addr),
        .fetch_addr(fetch_addr), .stack_fault(stack_fault)
    );

    function automatic string op_tag(input logic [2:0] o, input logic ld);
        case (o)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return ld ? "R8" : "R7";
            3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ptr = START; m_sp = 0; m_cnt = '0; m_fault = 1'b0;
        for (int i = 0; i < 16; i++) m_vec[i] = '0;
    endtask

    // Advance the model by one operation using the current inputs.
    task automatic model_update();
        logic [31:0] seq;
        logic [15:0] dec;
        seq = m_ptr + {28'd0, instr_len};
        case (op)
            3'd0: m_ptr = seq;
            3'd1: m_ptr = target;
            3'd2, 3'd6: begin
                if (m_sp == 8) m_fault = 1'b1;
                else begin
                    m_stack[m_sp] = seq; m_sp++;
                    m_ptr = (op == 3'd2) ? target : m_vec[int_num];
                end
            end
            3'd3, 3'd7: begin
                if (m_sp == 0) m_fault = 1'b1;
                else begin m_sp--; m_ptr = m_stack[m_sp]; end
            end
            3'd4: m_ptr = zero_flag ? target : seq;
            default: begin
                if (cnt_load) m_ptr = seq;
                else begin
                    dec = m_cnt - 16'd1;
                    m_ptr = (dec != 0) ? target : seq;
                    m_cnt = dec;
                end
            end
        endcase
        if (cnt_load) m_cnt = cnt_value;
        if (vec_we) m_vec[vec_idx] = vec_addr;
    endtask

    // One clock: model follows the edge, outputs compared 1 ns later.
    task automatic step();
        string tag;
        tag = op_tag(op, cnt_load);
        @(posedge clk);
        model_update();
        #1;
        check(tag, fetch_addr, m_ptr);
        check(m_fault ? "R12" : "R11", {31'd0, stack_fault}, {31'd0, m_fault});
    endtask

    task automatic drive(input logic [2:0] o, input logic [3:0] len, input logic [31:0] tgt);
        op = o; instr_len = len; target = tgt;
        step();
        cnt_load = 1'b0; vec_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op = 3'd0;
        @(posedge clk); @(posedge clk);
        #1 rst_n = 1'b1;
        model_reset();
        check("R1", fetch_addr, START);
        check("R1", {31'd0, stack_fault}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        do_reset();

        // R2, R3
        drive(3'd0, 4'd3, '0);
        drive(3'd0, 4'd15, '0);
        drive(3'd1, 4'd2, 32'h0000_2000);
        // R4, R5: nested calls unwind LIFO
        drive(3'd2, 4'd5, 32'h0000_3000);
        drive(3'd2, 4'd4, 32'h0000_4000);
        drive(3'd3, 4'd1, '0);
        drive(3'd3, 4'd1, '0);
        // R6 both polarities
        zero_flag = 1'b0; drive(3'd4, 4'd2, 32'h0000_5000);
        zero_flag = 1'b1; drive(3'd4, 4'd2, 32'h0000_5000);
        zero_flag = 1'b0;
        // R7: count 3 -> taken, taken, fall through
        cnt_load = 1'b1; cnt_value = 16'd3; drive(3'd0, 4'd1, '0);
        drive(3'd5, 4'd2, 32'h0000_6000);
        drive(3'd5, 4'd2, 32'h0000_6000);
        drive(3'd5, 4'd2, 32'h0000_6000);
        // R8: load wins over loop, count becomes 0
        cnt_load = 1'b1; cnt_value = 16'd0; drive(3'd5, 4'd3, 32'h0000_7000);
        // R7: count 0 wraps, branch taken
        drive(3'd5, 4'd3, 32'h0000_7100);
        // R9: table write then interrupt, then R10 return
        vec_we = 1'b1; vec_idx = 4'd5; vec_addr = 32'h0000_8000; drive(3'd0, 4'd1, '0);
        int_num = 4'd5; drive(3'd6, 4'd2, '0);
        drive(3'd7, 4'd1, '0);
        // R9: write in same cycle as interrupt uses old entry
        vec_we = 1'b1; vec_idx = 4'd5; vec_addr = 32'h0000_9000; int_num = 4'd5;
        drive(3'd6, 4'd2, '0);
        drive(3'd6, 4'd2, '0);
        drive(3'd7, 4'd1, '0);
        drive(3'd7, 4'd1, '0);
        // R11 underflow, R12 sticky
        drive(3'd3, 4'd1, '0);
        drive(3'd0, 4'd1, '0);
        drive(3'd1, 4'd1, 32'h0000_A000);
        do_reset();
        // R11 overflow after eight pushes
        for (int i = 0; i < 9; i++) drive(3'd2, 4'd4, 32'h0001_0000 + 32'(i * 16));
        drive(3'd6, 4'd2, '0);
        do_reset();

        // seeded random mix
        for (int i = 0; i < 3000; i++) begin
            if (i % 400 == 399) do_reset();
            zero_flag = 1'($urandom_range(0, 1));
            int_num   = 4'($urandom_range(0, 15));
            cnt_load  = ($urandom_range(0, 7) == 0);
            cnt_value = 16'($urandom_range(0, 5));
            vec_we    = ($urandom_range(0, 5) == 0);
            vec_idx   = 4'($urandom_range(0, 15));
            vec_addr  = $urandom;
            drive(3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)), $urandom);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule